// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to 32 single-cycle event pulses from device-side logic into a sticky status vector and reports them to a host processor through one interrupt line. A mask vector decides which latched events may reach that line. The host talks to the block over a minimal register bus, with one-cycle read and write strobes, a word address and 32-bit data.

The host has several views of the same two vectors. The mask can be written whole or changed bit by bit through separate set and clear aliases. Status can be read with no side effect, or read so that the read also clears it. Individual status bits can be acknowledged by writing ones. A control register enables the interrupt line and selects its polarity, so the line can drive either an active-high or an active-low host pin.

Register word addresses: 0 mask (read/write), 1 mask-set (write only), 2 mask-clear (write only), 3 status peek (read only), 4 status take, which clears on read (read only), 5 acknowledge (write only), 6 control (read/write, bit 0 enable, bit 1 active-low). Addresses 1, 2, 5 and 7 read as zero.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x00000001, status reads 0, control reads 0 and `irq_out` is 0.
- R2: A one-cycle pulse on `src_pulse[i]` sets status bit i, and the bit stays set until an acknowledge or a take read clears it.
- R3: A write to address 0 replaces the whole mask, and a read of address 0 returns it.
- R4: A write to address 1 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to address 2 clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R6: A read of address 3 returns the status vector and leaves it unchanged.
- R7: A read of address 4 returns the status vector, and every status bit is cleared on the same clock edge.
- R8: A write to address 5 clears the status bits whose data bit is 1. Both status views show the change, and zero data bits have no effect.
- R9: A source pulse in the same cycle as an acknowledge or take read of that bit leaves the bit set.
- R10: With control bit 0 set, `irq_out` is at its active level whenever status AND NOT mask is nonzero, and at its idle level otherwise. Control bit 1 selects active-low. With bit 0 clear the line sits at its idle level: 0 when active-high, 1 when active-low. The line is registered and follows status, mask and control one cycle after they change.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Write-only and unmapped addresses (1, 2, 5, 7) read as 0, and control reads back in bits [1:0].
- R12: A status bit whose mask bit is 1 does not assert `irq_out`. Because of the reset mask, a pulse on source 0 alone raises no interrupt after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 32 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Host interrupt line |

## Verification
A status bit that is lost, stuck or cleared too widely shows up at the next peek read, one cycle after its strobe, and also on `irq_out` one cycle after the state changes. A mask alias that touches bits outside its write data shows up at the next read of address 0, and also on the interrupt line once an unmasked source is pending. The bench puts pulses in the same cycle as acknowledges and take reads. A clear that wins over a new event leaves that event missing from the following peek.

// File: rtl/hisc_pkg.sv
package hisc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MASK = 3'd0,
    RA_MSET = 3'd1,
    RA_MCLR = 3'd2,
    RA_PEEK = 3'd3,
    RA_TAKE = 3'd4,
    RA_ACK  = 3'd5,
    RA_CTRL = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_LO_BIT = 1;
endpackage

// File: rtl/hisc_status.sv
module hisc_status #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pulse_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat_o[i] <= 1'b0;
      else     stat_o[i] <= (stat_o[i] & ~clr_i[i]) | pulse_i[i];
    end
  end

  // R2: every pulse leaves its bit set on the next cycle
  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_o & $past(pulse_i)) == $past(pulse_i)));

  // R2: bits not being cleared are never dropped
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));
endmodule

// File: rtl/hisc_mask.sv
module hisc_mask #(
  parameter int              NSRC      = 32,
  parameter logic [NSRC-1:0] RESET_VAL = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)         mask_o <= RESET_VAL;
    else if (load_i) mask_o <= data_i;
    else if (set_i)  mask_o <= mask_o | data_i;
    else if (clr_i)  mask_o <= mask_o & ~data_i;
  end

  // R4: set alias raises the written ones
  a_r4_set_ones: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(set_i) && !$past(load_i))
      |-> ((mask_o & $past(data_i)) == $past(data_i)));

  // R5: clear alias keeps untouched bits
  a_r5_clr_keeps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_i) && !$past(load_i) && !$past(set_i))
      |-> (mask_o == ($past(mask_o) & ~$past(data_i))));
endmodule

// File: rtl/hisc_irq_out.sv
module hisc_irq_out #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            low_i,
  input  logic [NSRC-1:0] stat_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_o
);
  logic pend;
  assign pend = |(stat_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (en_i & pend) ^ low_i;
  end

  // R10: disabled line sits at the idle level chosen by polarity
  a_r10_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_i)) |-> (irq_o == $past(low_i)));

  // R12: fully masked status never shows as active
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(stat_i) & ~$past(mask_i)) == '0))
      |-> (irq_o == $past(low_i)));
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hisc_pkg::*;
#(
  parameter int              NSRC      = 32,
  parameter int              DW        = 32,
  parameter logic [NSRC-1:0] MASK_INIT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_pulse,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq_out
);
  localparam int CTRL_W = 2;

  logic [NSRC-1:0] stat, mask, clr_vec, wsrc;
  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0] stat_ext, mask_ext, ctrl_ext;
  logic take_rd, ack_wr;

  assign wsrc    = bus_wdata[NSRC-1:0];
  assign take_rd = bus_rd && (bus_addr == RA_TAKE);
  assign ack_wr  = bus_wr && (bus_addr == RA_ACK);

  always_comb begin
    clr_vec = '0;
    if (ack_wr)  clr_vec = clr_vec | wsrc;
    if (take_rd) clr_vec = '1;
  end

  hisc_status #(.NSRC(NSRC)) u_status (
    .clk(clk), .rst(rst), .pulse_i(src_pulse), .clr_i(clr_vec), .stat_o(stat)
  );

  hisc_mask #(.NSRC(NSRC), .RESET_VAL(MASK_INIT)) u_mask (
    .clk(clk), .rst(rst),
    .load_i(bus_wr && (bus_addr == RA_MASK)),
    .set_i (bus_wr && (bus_addr == RA_MSET)),
    .clr_i (bus_wr && (bus_addr == RA_MCLR)),
    .data_i(wsrc), .mask_o(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (bus_wr && (bus_addr == RA_CTRL)) ctrl <= bus_wdata[CTRL_W-1:0];
  end

  hisc_irq_out #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst(rst),
    .en_i(ctrl[CTRL_EN_BIT]), .low_i(ctrl[CTRL_LO_BIT]),
    .stat_i(stat), .mask_i(mask), .irq_o(irq_out)
  );

  always_comb begin
    stat_ext = '0; stat_ext[NSRC-1:0] = stat;
    mask_ext = '0; mask_ext[NSRC-1:0] = mask;
    ctrl_ext = '0; ctrl_ext[CTRL_W-1:0] = ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        RA_MASK:          bus_rdata <= mask_ext;
        RA_PEEK, RA_TAKE: bus_rdata <= stat_ext;
        RA_CTRL:          bus_rdata <= ctrl_ext;
        default:          bus_rdata <= '0;
      endcase
    end
  end

  // R7: after a take read only same-cycle pulses survive
  a_r7_take_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take_rd)) |-> (stat == $past(src_pulse)));

  // R11: data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata));
endmodule

// File: tb/test_host_irq_ctrl.sv
module test_host_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_pulse = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_irq_ctrl i_host_irq_ctrl (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); src_pulse = v;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    rd(3'd0, d); chk("R1 mask", d, 32'h1);
    rd(3'd3, d); chk("R1 status", d, 32'h0);
    rd(3'd6, d); chk("R1 ctrl", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(32'h0000_4402);
    repeat (3) settle();
    rd(3'd3, d); chk("R2 sticky", d, 32'h4402);
    rd(3'd3, d); chk("R6 peek no clear", d, 32'h4402);
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(3'd6, 32'h1); settle();
    chk("R10 enabled active", {31'd0, irq_out}, 32'd1);
    wr(3'd1, 32'h4402); rd(3'd0, d); chk("R4 mask set", d, 32'h4403);
    chk("R12 masked quiet", {31'd0, irq_out}, 32'd0);
    wr(3'd2, 32'h0400); rd(3'd0, d); chk("R5 mask clear", d, 32'h4003);
    chk("R10 unmasked active", {31'd0, irq_out}, 32'd1);
    wr(3'd6, 32'h3); settle();
    chk("R10 active low", {31'd0, irq_out}, 32'd0);
    wr(3'd6, 32'h2); settle();
    chk("R10 disabled low idle", {31'd0, irq_out}, 32'd1);
    rd(3'd6, d); chk("R11 ctrl readback", d, 32'h2);
    wr(3'd6, 32'h1); settle();
  endtask

  task automatic t_ack_take();
    logic [31:0] d;
    wr(3'd5, 32'h0000_0002); rd(3'd3, d); chk("R8 ack one bit", d, 32'h4400);
    wr(3'd5, 32'h0000_0000); rd(3'd3, d); chk("R8 zero ack", d, 32'h4400);
    rd(3'd4, d); chk("R7 take returns", d, 32'h4400);
    rd(3'd3, d); chk("R7 take cleared", d, 32'h0);
    chk("R10 no pending", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(32'h8);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h8; src_pulse = 32'h8;
    @(negedge clk); bus_wr = 1'b0; src_pulse = '0;
    rd(3'd3, d); chk("R9 pulse beats ack", d, 32'h8);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd4; src_pulse = 32'h20;
    @(negedge clk); bus_rd = 1'b0; src_pulse = '0; d = bus_rdata;
    chk("R9 take old value", d, 32'h8);
    rd(3'd3, d); chk("R9 pulse beats take", d, 32'h20);
    wr(3'd5, 32'hFFFF_FFFF);
  endtask

  task automatic t_direct_mask();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_0000); rd(3'd0, d); chk("R3 mask write", d, 32'hFFFF_0000);
    wr(3'd0, 32'h1);
    pulse(32'h1); settle();
    rd(3'd3, d); chk("R12 src0 latched", d, 32'h1);
    chk("R12 src0 masked", {31'd0, irq_out}, 32'd0);
    wr(3'd2, 32'h1); settle();
    chk("R10 src0 unmasked", {31'd0, irq_out}, 32'd1);
  endtask

  task automatic t_map();
    logic [31:0] d;
    rd(3'd1, d); chk("R11 set alias reads 0", d, 32'h0);
    rd(3'd2, d); chk("R11 clr alias reads 0", d, 32'h0);
    rd(3'd5, d); chk("R11 ack reads 0", d, 32'h0);
    rd(3'd7, d); chk("R11 unmapped reads 0", d, 32'h0);
    repeat (2) settle();
    chk("R11 rdata holds", d, bus_rdata);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_sticky();
    t_irq_mask();
    t_ack_take();
    t_collide();
    t_direct_mask();
    t_map();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule